// File: doc/BRIEF.md
# Multi-Bank Glitch-Free Clock Divider

This block derives four families of divided clocks from a single fast input clock: three banks (A, B and C) of parallel outputs and one feedback-path output. Each bank picks its divide ratio from a 2-bit code. A shared prescale select either doubles every ratio or leaves it as it is. All outputs come from one final register stage clocked by the input clock, so outputs of the same ratio switch on the same edge.

The ratio of a running output can change at any time. The change waits for the end of the current output period, so every period is a complete period at either the old ratio or the new one. A per-output enable vector forces single outputs low. An invert control flips two of the bank C outputs in the same final register stage. The active-low master reset clears every flip-flop and holds all outputs low.

Top module: `clkdiv_banks`

## Requirements
- R1: With `pre_byp_i` low, every output's ratio is twice its bypass-mode value. With `pre_byp_i` high, the bypass-mode ratio applies.
- R2: Bank A bypass-mode ratios for `sel_a_i` = 0, 1, 2, 3 are 4, 6, 8, 12 input-clock cycles.
- R3: Bank B bypass-mode ratios for `sel_b_i` = 0, 1, 2, 3 are 4, 6, 8, 10.
- R4: Bank C bypass-mode ratios for `sel_c_i` = 0, 1, 2, 3 are 2, 4, 6, 8.
- R5: `fb_o` uses the bank A ratio table, selected by `sel_fb_i`.
- R6: Every enabled output is high for exactly half of its period and low for the other half.
- R7: While `inv_c_i` is high, `q_c_o[2]` and `q_c_o[3]` are the complement of `q_c_o[0]` and `q_c_o[1]`. While it is low, all four are equal. `q_c_o[0]` and `q_c_o[1]` are never inverted.
- R8: While `rst_n_i` is low, all outputs are low. On the first clock edge after release, every enabled output goes high on that same edge.
- R9: `out_en_i` bit i low drives one output low, one cycle later. The bit mapping is: bits [3:0] drive `q_a_o[3:0]`, bits [7:4] drive `q_b_o`, bits [11:8] drive `q_c_o`, and bit 12 drives `fb_o`. Outputs whose bit stays high keep toggling.
- R10: After a select or prescale change, every output period equals either the old or the new ratio. Once a period at the new ratio appears, no period at the old ratio follows. The new ratio is in force within a few periods. Selects and the invert control pass through a two-flop synchronizer first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_n_i | input | 1 | Active-low master reset; also disables all outputs |
| pre_byp_i | input | 1 | High: bypass the divide-by-2 prescaler |
| sel_a_i | input | 2 | Bank A ratio code |
| sel_b_i | input | 2 | Bank B ratio code |
| sel_c_i | input | 2 | Bank C ratio code |
| sel_fb_i | input | 2 | Feedback output ratio code (bank A table) |
| inv_c_i | input | 1 | Invert bank C outputs 2 and 3 |
| out_en_i | input | 13 | Per-output enable vector |
| q_a_o | output | 4 | Bank A clocks |
| q_b_o | output | 4 | Bank B clocks |
| q_c_o | output | 4 | Bank C clocks |
| fb_o | output | 1 | Feedback-path clock |

## Verification
The checker assumes `out_en_i` is synchronous to `clk_i`, because it relates each output to the enable seen on the edge before. It also assumes that no phase of `q_a_o[0]` lasts longer than half of the largest ratio. That bound can only be broken by a stretched period, so a glitch-free ratio change must never exceed it. The bench drives every input at the falling clock edge and holds each configuration for longer than the synchronizer latency plus one full period before measuring. During the ratio-change checks it records every period on both sides of the change.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
   localparam int RATIO_W = 5;
   typedef logic [RATIO_W-1:0] ratio_t;
   typedef enum logic [1:0] {BANK_A = 2'd0, BANK_B = 2'd1, BANK_C = 2'd2} bank_e;

   // Ratio in input-clock cycles; doubled when the prescaler is active.
   function automatic ratio_t div_ratio(bank_e bank, logic [1:0] code, logic pre_byp);
      ratio_t base;
      case (bank)
         BANK_A:  base = (code == 2'd3) ? ratio_t'(12) : ratio_t'(4 + 2 * code);
         BANK_B:  base = ratio_t'(4 + 2 * code);
         default: base = ratio_t'(2 + 2 * code);
      endcase
      return pre_byp ? base : ratio_t'(base << 1);
   endfunction
endpackage

// File: rtl/clkdiv_sync.sv
module clkdiv_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_n_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad
      $error("clkdiv_sync: STAGES must be at least 2");
   end

   logic [W-1:0] pipe [STAGES];

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
      end else begin
         pipe[0] <= d_i;
         for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
      end
   end

   assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
   import clkdiv_pkg::*;
#(
   parameter bank_e BANK = BANK_A
) (
   input  logic       clk_i,
   input  logic       rst_n_i,
   input  logic [1:0] code_i,
   input  logic       pre_byp_i,
   output logic       phase_o
);
   ratio_t cur_q;
   ratio_t cnt_q;
   logic   last_c;

   assign last_c = (cnt_q == cur_q - ratio_t'(1));

   // A new ratio is taken only on the last cycle of a full period.
   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         cur_q <= div_ratio(BANK, 2'd0, 1'b0);
         cnt_q <= '0;
      end else if (last_c) begin
         cur_q <= div_ratio(BANK, code_i, pre_byp_i);
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + ratio_t'(1);
      end
   end

   assign phase_o = (cnt_q < (cur_q >> 1));
endmodule

// File: rtl/clkdiv_outstage.sv
module clkdiv_outstage #(
   parameter int           N        = 4,
   parameter logic [N-1:0] INV_MASK = '0
) (
   input  logic         clk_i,
   input  logic         rst_n_i,
   input  logic         phase_i,
   input  logic         inv_i,
   input  logic [N-1:0] en_i,
   output logic [N-1:0] q_o
);
   logic [N-1:0] d_c;

   if (INV_MASK == '0) begin : g_plain
      assign d_c = en_i & {N{phase_i}};
   end else begin : g_inv
      assign d_c = en_i & ({N{phase_i}} ^ ({N{inv_i}} & INV_MASK));
   end

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) q_o <= '0;
      else          q_o <= d_c;
   end
endmodule

// File: rtl/clkdiv_banks.sv
module clkdiv_banks
   import clkdiv_pkg::*;
#(
   parameter int                   BANK_OUTS   = 4,
   parameter int                   SYNC_STAGES = 2,
   parameter logic [BANK_OUTS-1:0] INV_C_MASK  = 4'b1100,
   localparam int                  EN_W        = 3 * BANK_OUTS + 1
) (
   input  logic                 clk_i,
   input  logic                 rst_n_i,
   input  logic                 pre_byp_i,
   input  logic [1:0]           sel_a_i,
   input  logic [1:0]           sel_b_i,
   input  logic [1:0]           sel_c_i,
   input  logic [1:0]           sel_fb_i,
   input  logic                 inv_c_i,
   input  logic [EN_W-1:0]      out_en_i,
   output logic [BANK_OUTS-1:0] q_a_o,
   output logic [BANK_OUTS-1:0] q_b_o,
   output logic [BANK_OUTS-1:0] q_c_o,
   output logic                 fb_o
);
   localparam int NDIV   = 4;
   localparam int SYNC_W = 2 * NDIV + 2;

   if (BANK_OUTS < 1) begin : g_bad
      $error("clkdiv_banks: BANK_OUTS must be at least 1");
   end

   logic [SYNC_W-1:0] sync_s;
   logic [1:0]        code_s [NDIV];
   logic              byp_s;
   logic              inv_s;
   logic [NDIV-1:0]   phase;

   clkdiv_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) sync_i (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .d_i     ({inv_c_i, pre_byp_i, sel_fb_i, sel_c_i, sel_b_i, sel_a_i}),
      .q_o     (sync_s)
   );

   assign inv_s = sync_s[SYNC_W-1];
   assign byp_s = sync_s[SYNC_W-2];

   for (genvar g = 0; g < NDIV; g++) begin : g_div
      localparam bank_e BK = (g == 1) ? BANK_B : (g == 2) ? BANK_C : BANK_A;
      assign code_s[g] = sync_s[2*g+1 : 2*g];
      clkdiv_counter #(.BANK(BK)) cnt_i (
         .clk_i     (clk_i),
         .rst_n_i   (rst_n_i),
         .code_i    (code_s[g]),
         .pre_byp_i (byp_s),
         .phase_o   (phase[g])
      );
   end

   clkdiv_outstage #(.N(BANK_OUTS), .INV_MASK('0)) out_a_i (
      .clk_i (clk_i), .rst_n_i (rst_n_i), .phase_i (phase[0]), .inv_i (inv_s),
      .en_i  (out_en_i[BANK_OUTS-1:0]), .q_o (q_a_o)
   );
   clkdiv_outstage #(.N(BANK_OUTS), .INV_MASK('0)) out_b_i (
      .clk_i (clk_i), .rst_n_i (rst_n_i), .phase_i (phase[1]), .inv_i (inv_s),
      .en_i  (out_en_i[2*BANK_OUTS-1:BANK_OUTS]), .q_o (q_b_o)
   );
   clkdiv_outstage #(.N(BANK_OUTS), .INV_MASK(INV_C_MASK)) out_c_i (
      .clk_i (clk_i), .rst_n_i (rst_n_i), .phase_i (phase[2]), .inv_i (inv_s),
      .en_i  (out_en_i[3*BANK_OUTS-1:2*BANK_OUTS]), .q_o (q_c_o)
   );
   clkdiv_outstage #(.N(1), .INV_MASK(1'b0)) out_fb_i (
      .clk_i (clk_i), .rst_n_i (rst_n_i), .phase_i (phase[3]), .inv_i (inv_s),
      .en_i  (out_en_i[EN_W-1]), .q_o (fb_o)
   );
endmodule

// File: rtl/clkdiv_banks_chk.sv
module clkdiv_banks_chk #(
   parameter int N = 4
) (
   input logic             clk_i,
   input logic             rst_n_i,
   input logic [3*N:0]     out_en_i,
   input logic [N-1:0]     q_a_o,
   input logic [N-1:0]     q_b_o,
   input logic [N-1:0]     q_c_o,
   input logic             fb_o
);
   localparam int MAX_HALF = 12;

   logic [3*N:0] allq;
   logic [4:0]   run_q;
   logic         prev_q;

   assign allq = {fb_o, q_c_o, q_b_o, q_a_o};

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         run_q  <= '0;
         prev_q <= 1'b0;
      end else begin
         prev_q <= q_a_o[0];
         if (!out_en_i[0] || q_a_o[0] != prev_q) run_q <= '0;
         else if (run_q != 5'd31)                 run_q <= run_q + 5'd1;
      end
   end

   // R9
   disabled_low_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      1'b1 |=> ((allq & ~$past(out_en_i)) == '0));

   // R7
   c_plain_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (&$past(out_en_i[2*N+1:2*N])) |-> (q_c_o[0] == q_c_o[1]));

   // R7
   c_inv_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (&$past(out_en_i[2*N+3:2*N+2])) |-> (q_c_o[2] == q_c_o[3]));

   // R2
   bank_a_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (&$past(out_en_i[N-1:0])) |-> ($countones(q_a_o) == 0 || $countones(q_a_o) == N));

   // R10
   no_stretch_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      run_q <= 5'(MAX_HALF));
endmodule

bind clkdiv_banks clkdiv_banks_chk #(.N(BANK_OUTS)) chk_i (
   .clk_i    (clk_i),
   .rst_n_i  (rst_n_i),
   .out_en_i (out_en_i),
   .q_a_o    (q_a_o),
   .q_b_o    (q_b_o),
   .q_c_o    (q_c_o),
   .fb_o     (fb_o)
);

// File: tb/clkdiv_banks_tb_top.sv
`timescale 1ns/1ps
module clkdiv_banks_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pre_byp = 1'b0;
   logic [1:0]  sel_a = '0, sel_b = '0, sel_c = '0, sel_fb = '0;
   logic        inv_c = 1'b0;
   logic [12:0] out_en = '1;
   logic [3:0]  q_a, q_b, q_c;
   logic        fb;
   logic [12:0] allq;
   int          checks = 0;
   int          fails  = 0;
   bit          done   = 1'b0;

   always #2.5 clk = ~clk;

   assign allq = {fb, q_c, q_b, q_a};

   clkdiv_banks dut_i (
      .clk_i (clk), .rst_n_i (rst_n), .pre_byp_i (pre_byp),
      .sel_a_i (sel_a), .sel_b_i (sel_b), .sel_c_i (sel_c), .sel_fb_i (sel_fb),
      .inv_c_i (inv_c), .out_en_i (out_en),
      .q_a_o (q_a), .q_b_o (q_b), .q_c_o (q_c), .fb_o (fb)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // bank: 0=A, 1=B, 2=C, 3=FB (A table)
   function automatic int exp_ratio(input int bank, input int code, input bit byp);
      int r;
      case (bank)
         1:       r = 4 + 2 * code;
         2:       r = 2 + 2 * code;
         default: r = (code == 3) ? 12 : 4 + 2 * code;
      endcase
      return byp ? r : 2 * r;
   endfunction

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Measure one full period (rise to rise) and its high time, sampled at negedges.
   task automatic meas(input int idx, output int per, output int hi);
      bit prev;
      int guard;
      per = 0; hi = 0; guard = 0;
      prev = allq[idx];
      forever begin
         @(negedge clk);
         guard++;
         if (!prev && allq[idx]) break;
         prev = allq[idx];
         if (guard > 200) return;
      end
      per = 1; hi = 1; prev = 1'b1;
      forever begin
         @(negedge clk);
         if (!prev && allq[idx]) break;
         per++;
         if (allq[idx]) hi++;
         prev = allq[idx];
         if (per > 200) begin per = 0; return; end
      end
   endtask

   task automatic transition(input int idx, input int bank, input int c_old, input int c_new,
                             input bit b_old, input bit b_new, input string req);
      int ro, rn, per, hi;
      bit seen_new;
      ro = exp_ratio(bank, c_old, b_old);
      rn = exp_ratio(bank, c_new, b_new);
      seen_new = 1'b0;
      sel_a = 2'(c_new); sel_c = 2'(c_new); pre_byp = b_new;
      for (int k = 0; k < 5; k++) begin
         meas(idx, per, hi);
         chk(per == ro || per == rn, req, per, rn);
         chk(!(seen_new && per == ro && ro != rn), req, per, rn);
         if (per == rn) seen_new = 1'b1;
         if (k == 4) chk(per == rn, req, per, rn);
      end
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int per, hi, e, bad, hib;
      // R8: reset state
      wait_cyc(4);
      chk(allq == 13'h0, "R8 reset low", int'(allq), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(allq == 13'h1fff, "R8 aligned first rise", int'(allq), 13'h1fff);

      // R1..R6: sweep prescale and every code
      for (int b = 0; b < 2; b++) begin
         for (int c = 0; c < 4; c++) begin
            pre_byp = b[0];
            sel_a = 2'(c); sel_b = 2'(c); sel_c = 2'(c); sel_fb = 2'(3 - c);
            wait_cyc(80);
            meas(0, per, hi);  e = exp_ratio(0, c, b[0]);
            chk(per == e, "R2 R1 bank A ratio", per, e);
            chk(2 * hi == per, "R6 bank A duty", hi, per / 2);
            meas(4, per, hi);  e = exp_ratio(1, c, b[0]);
            chk(per == e, "R3 R1 bank B ratio", per, e);
            chk(2 * hi == per, "R6 bank B duty", hi, per / 2);
            meas(8, per, hi);  e = exp_ratio(2, c, b[0]);
            chk(per == e, "R4 R1 bank C ratio", per, e);
            chk(2 * hi == per, "R6 bank C duty", hi, per / 2);
            meas(12, per, hi); e = exp_ratio(3, 3 - c, b[0]);
            chk(per == e, "R5 R1 feedback ratio", per, e);
            chk(2 * hi == per, "R6 feedback duty", hi, per / 2);
         end
      end

      // R7: inversion of C2/C3 only
      pre_byp = 1'b1; sel_c = 2'd1; inv_c = 1'b1;
      wait_cyc(20);
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         chk(q_c[2] == ~q_c[0] && q_c[3] == ~q_c[1] && q_c[0] == q_c[1],
             "R7 inverted pair", int'(q_c), int'({~q_c[0], ~q_c[0], q_c[0], q_c[0]}));
      end
      inv_c = 1'b0;
      wait_cyc(20);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk(q_c == {4{q_c[0]}}, "R7 no inversion", int'(q_c), int'({4{q_c[0]}}));
      end

      // R9: enable vector
      out_en = 13'h1fff & ~13'h1420;  // B1, C2, FB off
      wait_cyc(2);
      bad = 0; hib = 0;
      for (int k = 0; k < 60; k++) begin
         @(negedge clk);
         if (q_b[1] || q_c[2] || fb) bad++;
         if (q_b[0]) hib++;
      end
      chk(bad == 0, "R9 disabled outputs low", bad, 0);
      chk(hib > 0, "R9 enabled output toggles", hib, 30);
      out_en = '1;
      wait_cyc(2);
      meas(12, per, hi); e = exp_ratio(3, sel_fb, pre_byp);
      chk(per == e, "R9 feedback re-enabled", per, e);

      // R10: ratio changes while running
      pre_byp = 1'b1; sel_a = 2'd0; sel_c = 2'd0;
      wait_cyc(60);
      transition(0, 0, 0, 3, 1'b1, 1'b1, "R10 A 4->12");
      wait_cyc(30);
      transition(0, 0, 3, 0, 1'b1, 1'b1, "R10 A 12->4");
      wait_cyc(30);
      transition(8, 2, 0, 0, 1'b1, 1'b0, "R10 R1 C prescale on");

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule